// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host processor read and write a bank of 24-bit control registers over a four-wire serial link. The link has a select line, a serial clock and a host-to-slave data line. The return data line can be switched to high impedance. The select line is active high. Each transfer is one fixed 32-bit frame. The first bit chooses read or write. A 6-bit register address follows, then one spare bit, then 24 data bits.

All three serial inputs are re-timed into the system clock domain, and every action happens on system clock edges. A state machine follows each frame through four states:

- `ST_IDLE` waits for select.
- `ST_SHIFT` collects bits and drives return data.
- `ST_COMMIT` is a single-cycle write strobe to the register file.
- `ST_DONE` holds after a complete frame until select is released.

The transitions are:

- `ST_IDLE`→`ST_SHIFT` when select rises.
- `ST_SHIFT`→`ST_IDLE` on abort, when select falls early.
- `ST_SHIFT`→`ST_COMMIT` on the 32nd rising edge of a write frame.
- `ST_SHIFT`→`ST_DONE` on the 32nd rising edge of a read frame.
- `ST_COMMIT`→`ST_DONE` while still selected, or `ST_COMMIT`→`ST_IDLE` if select has been released.
- `ST_DONE`→`ST_IDLE` when select falls.

The register file attaches through an address, write data, a write strobe, read data and a per-bit writable mask for the addressed register. Bits that are not writable keep their stored value, because the block merges them from the read data into the write word.

Top module: `sreg_spi_slave`

## Requirements
- R1: Select is active high. While select is low, or after reset, no write strobe occurs and serial clock activity is ignored. A frame begins when select rises.
- R2: A frame is 32 bits, sent MSB first and sampled on serial clock rising edges. Bit 31 is the direction (1 = write, 0 = read). Bits 30:25 are the address. Bit 24 is ignored. Bits 23:0 are data.
- R3: A write frame produces exactly one single-cycle `rf_we_o` pulse after its 32nd rising edge, carrying the frame's address and data. The address is held steady during the pulse.
- R4: If select falls before the 32nd rising edge, the frame is discarded and no register changes.
- R5: Bits whose `rf_wmask_i` bit is 0 are not written. During the strobe, `rf_wdata_o` carries the current `rf_rdata_i` value in those positions.
- R6: In a read frame, the addressed register is shifted out on `miso_o` MSB first, one bit per data bit. `miso_o` changes only after serial clock falling edges. The host samples register bit 23 on the 9th rising edge.
- R7: `miso_oe_o` is high while the frame is selected. It drops no later than three system clocks after select falls.
- R8: After a complete frame, further serial clocks are ignored, including a whole second frame, until select goes low and high again.
- R9: A read frame never produces a write strobe.
- R10: Inputs are synchronised to `clk`. Correct operation needs `clk` to be at least four times the serial clock, and holds at any serial clock rate slower than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_i | input | 1 | Select, active high |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Host-to-slave data |
| miso_o | output | 1 | Slave-to-host data value |
| miso_oe_o | output | 1 | Pad enable for `miso_o`; pad is high impedance when low |
| rf_addr_o | output | 6 | Register file address |
| rf_wdata_o | output | 24 | Merged write word |
| rf_we_o | output | 1 | Single-cycle write strobe |
| rf_rdata_i | input | 24 | Contents of the addressed register |
| rf_wmask_i | input | 24 | Writable-bit mask of the addressed register |

## Verification
The assertions check every cycle that:

- the write strobe lasts one cycle, follows a selected cycle and keeps its address steady;
- non-writable bits of the write word equal the stored value;
- the output enable falls once select is seen low;
- the return data moves only after a falling serial clock edge.

Only the bench scenarios can show that frames are assembled correctly from the serial stream, and that reads return what earlier writes left behind. The same holds for the following cases: a truncated frame leaves the register untouched, surplus clocks or a second frame under one select do nothing, and a slower serial clock gives the same results.

// File: rtl/sreg_spi_pkg.sv
package sreg_spi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_DONE   = 2'd3
    } xfer_state_t;

endpackage

// File: rtl/sreg_spi_sync.sv
module sreg_spi_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sreg_spi_fsm.sv
module sreg_spi_fsm
    import sreg_spi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,
    input  logic sck_rise,
    input  logic last_bit,
    input  logic is_write,
    output logic clr_o,
    output logic shift_en_o,
    output logic commit_o,
    output logic drive_o
);

    xfer_state_t state_q;
    xfer_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_s) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!sel_s) begin
                    state_d = ST_IDLE;              // abort: partial frame dropped
                end else if (sck_rise && last_bit) begin
                    state_d = is_write ? ST_COMMIT : ST_DONE;
                end
            end
            ST_COMMIT: begin
                state_d = sel_s ? ST_DONE : ST_IDLE;
            end
            ST_DONE: begin
                if (!sel_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        clr_o      = 1'b0;
        shift_en_o = 1'b0;
        commit_o   = 1'b0;
        drive_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clr_o = 1'b1;
            end
            ST_SHIFT: begin
                shift_en_o = 1'b1;
                drive_o    = 1'b1;
            end
            ST_COMMIT: begin
                commit_o = 1'b1;
                drive_o  = 1'b1;
            end
            ST_DONE: begin
                drive_o = 1'b1;
            end
            default: clr_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/sreg_spi_dpath.sv
module sreg_spi_dpath #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rf_rdata_i,
    input  logic [DATA_W-1:0] rf_wmask_i,
    output logic              last_bit,
    output logic              is_write,
    output logic [ADDR_W-1:0] rf_addr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              miso_o
);

    localparam int FRAME_W = DATA_W + ADDR_W + 2;
    localparam int HDR_W   = ADDR_W + 2;
    localparam int RX_W    = FRAME_W - 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    logic [RX_W-1:0]   rx_q;
    logic [DATA_W-1:0] tx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q   <= '0;
            tx_q   <= '0;
            cnt_q  <= '0;
            addr_q <= '0;
            miso_q <= 1'b0;
        end else if (clr) begin
            rx_q   <= '0;
            tx_q   <= '0;
            cnt_q  <= '0;
            miso_q <= 1'b0;
        end else if (shift_en && sck_rise) begin
            rx_q  <= {rx_q[RX_W-2:0], mosi_s};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_ADDR) begin
                addr_q <= {rx_q[ADDR_W-2:0], mosi_s};
            end
            if (cnt_q == CNT_LOAD) begin
                tx_q <= rf_rdata_i;
            end
        end else if (shift_en && sck_fall && (cnt_q >= CNT_HDR)) begin
            miso_q <= tx_q[DATA_W-1];
            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    assign last_bit   = (cnt_q == CNT_LAST);
    assign is_write   = rx_q[RX_W-1];
    assign rf_addr_o  = addr_q;
    assign rf_wdata_o = (rx_q[DATA_W-1:0] & rf_wmask_i) | (rf_rdata_i & ~rf_wmask_i);
    assign miso_o     = miso_q;

endmodule

// File: rtl/sreg_spi_slave.sv
module sreg_spi_slave
    import sreg_spi_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_i,
    input  logic              sck_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic [ADDR_W-1:0] rf_addr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              rf_we_o,
    input  logic [DATA_W-1:0] rf_rdata_i,
    input  logic [DATA_W-1:0] rf_wmask_i
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] pins_s;
    logic sel_s, sck_s, mosi_s;
    logic sck_d;
    logic sck_rise, sck_fall;
    logic clr, shift_en, commit, drive;
    logic last_bit, is_write;

    // R10: all serial inputs re-timed through the same depth
    sreg_spi_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ss_i, sck_i, mosi_i}),
        .sync_o  (pins_s)
    );

    assign sel_s  = pins_s[2];
    assign sck_s  = pins_s[1];
    assign mosi_s = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
        end else begin
            sck_d <= sck_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;

    sreg_spi_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_s      (sel_s),
        .sck_rise   (sck_rise),
        .last_bit   (last_bit),
        .is_write   (is_write),
        .clr_o      (clr),
        .shift_en_o (shift_en),
        .commit_o   (commit),
        .drive_o    (drive)
    );

    sreg_spi_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .shift_en   (shift_en),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .mosi_s     (mosi_s),
        .rf_rdata_i (rf_rdata_i),
        .rf_wmask_i (rf_wmask_i),
        .last_bit   (last_bit),
        .is_write   (is_write),
        .rf_addr_o  (rf_addr_o),
        .rf_wdata_o (rf_wdata_o),
        .miso_o     (miso_o)
    );

    assign rf_we_o   = commit;
    assign miso_oe_o = drive;

endmodule

// File: rtl/sreg_spi_chk.sv
module sreg_spi_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_s,
    input logic              sck_fall,
    input logic              rf_we_o,
    input logic [ADDR_W-1:0] rf_addr_o,
    input logic [DATA_W-1:0] rf_wdata_o,
    input logic [DATA_W-1:0] rf_rdata_i,
    input logic [DATA_W-1:0] rf_wmask_i,
    input logic              miso_o,
    input logic              miso_oe_o
);

    AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> !rf_we_o);                                                   // R3

    AST_WE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> $stable(rf_addr_o));                                         // R3

    AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> $past(sel_s));                                               // R4

    AST_RO_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (((rf_wdata_o ^ rf_rdata_i) & ~rf_wmask_i) == '0));          // R5

    AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe_o && $past(miso_oe_o) && !$stable(miso_o)) |-> $past(sck_fall)); // R6

    AST_OE_OFF_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> !miso_oe_o);                                                  // R7

endmodule

bind sreg_spi_slave sreg_spi_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_s      (sel_s),
    .sck_fall   (sck_fall),
    .rf_we_o    (rf_we_o),
    .rf_addr_o  (rf_addr_o),
    .rf_wdata_o (rf_wdata_o),
    .rf_rdata_i (rf_rdata_i),
    .rf_wmask_i (rf_wmask_i),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o)
);

// File: tb/sreg_spi_slave_tb_top.sv
module sreg_spi_slave_tb_top;

    localparam int AW   = 6;
    localparam int DW   = 24;
    localparam int HALF = 6;
    localparam int NVEC = 8;

    // {address, data}
    localparam logic [29:0] VEC [NVEC] = '{
        {6'd0,  24'hA5A5A5},
        {6'd1,  24'h123456},
        {6'd2,  24'hFFFFFF},
        {6'd5,  24'h000000},
        {6'd63, 24'hABCDEF},
        {6'd62, 24'h800001},
        {6'd1,  24'hFEDCBA},
        {6'd33, 24'h5A5A5A}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ss = 1'b0;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_oe, rf_we;
    logic [AW-1:0] rf_addr;
    logic [DW-1:0] rf_wdata, rf_rdata, rf_wmask;

    logic [DW-1:0] mem    [64];
    logic [DW-1:0] shadow [64];
    int we_cnt = 0;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] mask_of(input int a);
        if (a == 63) return '0;
        if ((a % 2) == 1) return 24'h0F0F0F;
        return 24'hFFFFFF;
    endfunction

    function automatic logic [DW-1:0] init_of(input int a);
        return 24'h3C3C00 ^ 24'(a * 24'h010203);
    endfunction

    function automatic logic [31:0] mk(input logic w, input int a, input logic [DW-1:0] d, input logic rsv);
        return {w, 6'(a), rsv, d};
    endfunction

    assign rf_rdata = mem[rf_addr];
    assign rf_wmask = mask_of(int'(rf_addr));

    always @(posedge clk) begin
        if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    sreg_spi_slave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ss_i       (ss),
        .sck_i      (sck),
        .mosi_i     (mosi),
        .miso_o     (miso),
        .miso_oe_o  (miso_oe),
        .rf_addr_o  (rf_addr),
        .rf_wdata_o (rf_wdata),
        .rf_we_o    (rf_we),
        .rf_rdata_i (rf_rdata),
        .rf_wmask_i (rf_wmask)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one selected burst of nbits clocks; keep leaves select high afterwards
    task automatic xfer(input logic [31:0] frm, input int nbits, input int half,
                        input bit keep, output logic [DW-1:0] rd);
        rd = '0;
        ss = 1'b1;
        wclk(4);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 32) ? frm[31-i] : 1'b1;
            wclk(half);
            if (i >= 8 && i < 32) rd = {rd[DW-2:0], miso};
            sck = 1'b1;
            wclk(half);
            sck = 1'b0;
        end
        wclk(half);
        if (!keep) ss = 1'b0;
        wclk(4);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic [DW-1:0] m;
        int n0, a;
        for (int i = 0; i < 64; i++) begin
            mem[i]    = init_of(i);
            shadow[i] = init_of(i);
        end
        wclk(3);
        rst_n = 1'b1;
        wclk(3);

        // Reset state
        chk("R1 reset output enable", 32'(miso_oe), 32'd0);
        chk("R1 reset no write", 32'(we_cnt), 32'd0);

        // Table walk: write then read back each entry
        for (int k = 0; k < NVEC; k++) begin
            a = int'(VEC[k][29:24]);
            m = mask_of(a);
            n0 = we_cnt;
            xfer(mk(1'b1, a, VEC[k][23:0], 1'b0), 32, HALF, 1'b0, rd);
            chk("R3 one write pulse", 32'(we_cnt - n0), 32'd1);
            shadow[a] = (VEC[k][23:0] & m) | (shadow[a] & ~m);
            n0 = we_cnt;
            xfer(mk(1'b0, a, 24'h0, 1'b0), 32, HALF, 1'b0, rd);
            if (m != 24'hFFFFFF) chk("R5 masked readback", 32'(rd), 32'(shadow[a]));
            else                 chk("R6 readback", 32'(rd), 32'(shadow[a]));
            chk("R9 read makes no write", 32'(we_cnt - n0), 32'd0);
        end

        // R2: spare bit ignored, neighbour untouched
        xfer(mk(1'b1, 8, 24'h123ABC, 1'b1), 32, HALF, 1'b0, rd);
        shadow[8] = 24'h123ABC;
        xfer(mk(1'b0, 8, 24'h0, 1'b1), 32, HALF, 1'b0, rd);
        chk("R2 spare bit ignored", 32'(rd), 32'(shadow[8]));
        xfer(mk(1'b0, 10, 24'h0, 1'b0), 32, HALF, 1'b0, rd);
        chk("R2 neighbour address untouched", 32'(rd), 32'(shadow[10]));

        // R4: aborted frames
        n0 = we_cnt;
        xfer(mk(1'b1, 4, 24'h000000, 1'b0), 20, HALF, 1'b0, rd);
        xfer(mk(1'b1, 4, 24'h111111, 1'b0), 31, HALF, 1'b0, rd);
        chk("R4 abort no write", 32'(we_cnt - n0), 32'd0);
        xfer(mk(1'b0, 4, 24'h0, 1'b0), 32, HALF, 1'b0, rd);
        chk("R4 abort register unchanged", 32'(rd), 32'(shadow[4]));

        // R8: surplus clocks, then a second frame under the same select
        n0 = we_cnt;
        xfer(mk(1'b1, 6, 24'h0F00F0, 1'b0), 40, HALF, 1'b0, rd);
        shadow[6] = 24'h0F00F0;
        chk("R8 surplus clocks one write", 32'(we_cnt - n0), 32'd1);
        n0 = we_cnt;
        xfer(mk(1'b1, 7, 24'hFFFFFF, 1'b0), 32, HALF, 1'b1, rd);
        xfer(mk(1'b1, 7, 24'h000000, 1'b0), 32, HALF, 1'b0, rd);
        shadow[7] = (24'hFFFFFF & mask_of(7)) | (shadow[7] & ~mask_of(7));
        chk("R8 second frame ignored", 32'(we_cnt - n0), 32'd1);
        xfer(mk(1'b0, 7, 24'h0, 1'b0), 32, HALF, 1'b0, rd);
        chk("R8 readback after held select", 32'(rd), 32'(shadow[7]));

        // R1: clocks with select low do nothing
        n0 = we_cnt;
        for (int i = 0; i < 32; i++) begin
            mosi = 1'b1;
            wclk(HALF);
            sck = 1'b1;
            wclk(HALF);
            sck = 1'b0;
        end
        chk("R1 unselected clocks no write", 32'(we_cnt - n0), 32'd0);

        // R7: enable follows select
        ss = 1'b1;
        wclk(5);
        chk("R7 enable while selected", 32'(miso_oe), 32'd1);
        ss = 1'b0;
        wclk(4);
        chk("R7 enable off after release", 32'(miso_oe), 32'd0);

        // R10: slower serial clock
        n0 = we_cnt;
        xfer(mk(1'b1, 12, 24'hC0FFEE, 1'b0), 32, 11, 1'b0, rd);
        shadow[12] = 24'hC0FFEE;
        xfer(mk(1'b0, 12, 24'h0, 1'b0), 32, 11, 1'b0, rd);
        chk("R10 slow clock readback", 32'(rd), 32'(shadow[12]));
        chk("R10 slow clock one write", 32'(we_cnt - n0), 32'd1);

        summary();
        $finish;
    end

endmodule